// File: doc/BRIEF.md
# Accumulator Instruction-Cycle Sequencer

This block is the control sequencer and register set of a small single-accumulator machine. Instruction and data words are both 16 bits wide. The block runs every instruction through an explicit chain of one-clock phases: next-instruction address, instruction fetch, decode, operand address, operand fetch, data operation and result store. After the last phase that an instruction needs, it returns to the address phase. Each opcode decides which of the operand phases it visits. An instruction that touches no memory operand skips them all. A store computes an address but skips the operand read.

The machine drives an external synchronous single-port memory of 4096 words. It presents an address and a read strobe in one clock and takes the read data on the following clock. The current phase comes out as a 3-bit status code, so a system can follow the sequence from outside. The accumulator and the program counter are also visible.

Top module: `acc_cycle_ctrl`

## Requirements
- R1: While reset is low, the phase is 0 (address phase), the program counter and accumulator are 0, `halted` is 0 and `mem_wr` is 0.
- R2: Phase codes are: 0 address, 1 instruction fetch, 2 decode, 3 operand address, 4 operand fetch, 5 operation, 6 store, 7 halted. Each phase lasts one clock, and they occur only in ascending order, except for the return from the last phase of an instruction to phase 0.
- R3: In phase 0, `mem_rd` is high and `mem_addr` equals the program counter. Across the fetch phase, the program counter advances by exactly one.
- R4: Opcode 0x1 (load) runs phases 0,1,2,3,4,5 and leaves the accumulator equal to the addressed memory word.
- R5: Opcode 0x5 (add) runs phases 0,1,2,3,4,5 and adds the addressed word to the accumulator, modulo 2^16.
- R6: Opcode 0x2 (store) runs phases 0,1,2,3,5,6, skipping operand fetch. It writes the accumulator to the addressed word with one `mem_wr` pulse in phase 6.
- R7: Every opcode other than 0x0, 0x1, 0x2 and 0x5 runs phases 0,1,2,5 only. It makes no operand access and leaves the accumulator unchanged.
- R8: Opcode 0x0 (halt) runs phases 0,1,2 and then holds phase 7 until reset. While halted, `halted` is 1, there are no memory strobes and the program counter does not change.
- R9: An instruction word carries its opcode in bits 15:12 and its operand address in bits 11:0. In phase 3, `mem_addr` equals bits 11:0.
- R10: `mem_wr` is high only in phase 6. `mem_rd` is high only in phase 0, and in phase 3 of a load or an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 16 | Memory read data, valid the clock after the address |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| phase_o | output | 3 | Current phase code |
| halted | output | 1 | High in the halted phase |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |

## Verification
The bench runs a short program and records the exact phase trail of each instruction. A sequencer that took an operand fetch on a store, or entered operand phases on a no-op, would show an extra step or a missing step in that trail. An add whose sum crosses 2^16 catches a result that does not wrap or that leaks a carry. A load of the word that an earlier store wrote catches a write with the wrong data or the wrong address. The halt phase is watched over many clocks for strobes or counter movement, and a reset in the middle of an instruction must bring every register back to its reset value.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    PH_IADDR  = 3'd0,
    PH_IFETCH = 3'd1,
    PH_DECODE = 3'd2,
    PH_OADDR  = 3'd3,
    PH_OFETCH = 3'd4,
    PH_EXEC   = 3'd5,
    PH_OSTORE = 3'd6,
    PH_HALT   = 3'd7
  } phase_e;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h5;

  // opcode needs a memory operand address
  function automatic logic uses_addr(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
  endfunction

  // opcode reads its operand from memory
  function automatic logic reads_operand(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD);
  endfunction

  // opcode writes a result back to memory
  function automatic logic writes_result(input logic [OPC_W-1:0] op);
    return op == OP_STORE;
  endfunction

  function automatic phase_e next_phase(input phase_e ph, input logic [OPC_W-1:0] op);
    phase_e nx;
    case (ph)
      PH_IADDR:  nx = PH_IFETCH;
      PH_IFETCH: nx = PH_DECODE;
      PH_DECODE: begin
        if (op == OP_HALT)     nx = PH_HALT;
        else if (uses_addr(op)) nx = PH_OADDR;
        else                    nx = PH_EXEC;
      end
      PH_OADDR:  nx = reads_operand(op) ? PH_OFETCH : PH_EXEC;
      PH_OFETCH: nx = PH_EXEC;
      PH_EXEC:   nx = writes_result(op) ? PH_OSTORE : PH_IADDR;
      PH_OSTORE: nx = PH_IADDR;
      default:   nx = PH_HALT;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
  import acc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op,
  output phase_e           phase
);

  phase_e phase_nx;

  always_comb phase_nx = next_phase(phase, op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IADDR;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OPC_W-1:0]  ir_op,
  output logic [ADDR_W-1:0] ir_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] acc,
  output logic              acc_write
);

  logic [DATA_W-1:0] ir;

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  assign ir_op     = ir[DATA_W-1 -: OPC_W];
  assign ir_addr   = ir[ADDR_W-1:0];
  assign acc_write = (phase == PH_EXEC) && reads_operand(ir_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
      acc <= '0;
    end else begin
      case (phase)
        PH_IADDR:  mar <= pc;
        PH_IFETCH: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
        end
        PH_OADDR:  mar <= ir_addr;
        PH_OFETCH: mbr <= mem_rdata;
        PH_EXEC: begin
          if (ir_op == OP_LOAD)       acc <= mbr;
          else if (ir_op == OP_ADD)   acc <= add_wrap(acc, mbr);
          else if (ir_op == OP_STORE) mbr <= acc;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_mem_port.sv
module acc_mem_port
  import acc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
)(
  input  phase_e            phase,
  input  logic [OPC_W-1:0]  op,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] ir_addr,
  input  logic [ADDR_W-1:0] mar,
  input  logic [DATA_W-1:0] mbr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata
);

  always_comb begin
    case (phase)
      PH_IADDR: mem_addr = pc;
      PH_OADDR: mem_addr = ir_addr;
      default:  mem_addr = mar;
    endcase
    mem_rd    = (phase == PH_IADDR) || ((phase == PH_OADDR) && reads_operand(op));
    mem_wr    = phase == PH_OSTORE;
    mem_wdata = mbr;
  end

endmodule

// File: rtl/acc_cycle_ctrl.sv
module acc_cycle_ctrl
  import acc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [2:0]        phase_o,
  output logic              halted,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);

  phase_e            phase;
  logic [OPC_W-1:0]  ir_op;
  logic [ADDR_W-1:0] ir_addr;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] acc;
  logic              acc_write;

  acc_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (ir_op),
    .phase (phase)
  );

  acc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .mem_rdata (mem_rdata),
    .ir_op     (ir_op),
    .ir_addr   (ir_addr),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .acc       (acc),
    .acc_write (acc_write)
  );

  acc_mem_port #(.ADDR_W(ADDR_W)) u_port (
    .phase     (phase),
    .op        (ir_op),
    .pc        (pc),
    .ir_addr   (ir_addr),
    .mar       (mar),
    .mbr       (mbr),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata)
  );

  assign phase_o = phase;
  assign halted  = phase == PH_HALT;
  assign acc_o   = acc;
  assign pc_o    = pc;

endmodule

// File: rtl/acc_ctrl_chk.sv
module acc_ctrl_chk
  import acc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DATA_W = OPC_W + ADDR_W
)(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        phase,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [OPC_W-1:0]  op,
  input logic [DATA_W-1:0] acc,
  input logic              acc_write
);

  p_iaddr_then_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IADDR |=> phase == PH_IFETCH);

  p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DECODE |-> $past(phase) == PH_IFETCH);

  p_fetch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IADDR |-> mem_rd && mem_addr == pc);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IFETCH |=> pc == ADDR_W'($past(pc) + 1'b1));

  p_ofetch_after_oaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_OFETCH |-> $past(phase) == PH_OADDR);

  p_store_skips_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OADDR && op == OP_STORE) |=> phase == PH_EXEC);

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |=> acc == $past(acc));

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HALT |=> phase == PH_HALT && pc == $past(pc));

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HALT |-> !mem_rd && !mem_wr);

  p_wr_only_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> phase == PH_OSTORE);

endmodule

bind acc_cycle_ctrl acc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase_o),
  .pc        (pc_o),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .op        (ir_op),
  .acc       (acc_o),
  .acc_write (acc_write)
);

// File: tb/tb_acc_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_acc_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata, acc_o;
  logic [2:0]  phase_o;
  logic [11:0] pc_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .phase_o(phase_o), .halted(halted), .acc_o(acc_o), .pc_o(pc_o)
  );

  // bench memory: 256 words, data returned the clock after the address
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
  end

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] acc;
    logic [3:0]  cyc;
    logic [17:0] trail;
    logic        wr;
  } vec_t;

  // program in memory order; trail holds phase codes as octal digits
  localparam vec_t VEC [0:7] = '{
    '{16'h1080, 16'h1234, 4'd6, 18'o012345, 1'b0},  // load 0x80
    '{16'h5081, 16'h0243, 4'd6, 18'o012345, 1'b0},  // add 0x81, wraps
    '{16'h2083, 16'h0243, 4'd6, 18'o012356, 1'b0},  // store 0x83 (wr checked apart)
    '{16'h7ABC, 16'h0243, 4'd4, 18'o0125,   1'b0},  // no-op 0x7
    '{16'h5082, 16'h0242, 4'd6, 18'o012345, 1'b0},  // add 0xFFFF
    '{16'hF000, 16'h0242, 4'd4, 18'o0125,   1'b0},  // no-op 0xF
    '{16'h1083, 16'h0243, 4'd6, 18'o012345, 1'b0},  // load stored word
    '{16'h0000, 16'h0243, 4'd4, 18'o0127,   1'b0}   // halt
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0: return "R8";
      4'h1: return "R4";
      4'h2: return "R6";
      4'h5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic run_one(input int k);
    logic [17:0] tr = '0;
    int n = 0;
    bit done = 0;
    bit saw_wr = 0;
    logic [11:0] wa = '0;
    logic [15:0] wd = '0;
    vec_t v = VEC[k];
    string t = tag_of(v.instr[15:12]);
    while (!done) begin
      if (phase_o == 3'd0)
        chk(mem_rd && mem_addr == pc_o, "R3 fetch address", {20'd0, mem_addr}, {20'd0, pc_o});
      if (phase_o == 3'd3)
        chk(mem_addr == v.instr[11:0], "R9 operand address field", {20'd0, mem_addr}, {20'd0, v.instr[11:0]});
      if (mem_rd && phase_o != 3'd0 && phase_o != 3'd3)
        chk(1'b0, "R10 read strobe outside phase 0/3", {29'd0, phase_o}, 32'd0);
      if (mem_wr) begin
        saw_wr = 1; wa = mem_addr; wd = mem_wdata;
        chk(phase_o == 3'd6, "R10 write strobe phase", {29'd0, phase_o}, 32'd6);
      end
      tr = {tr[14:0], phase_o};
      n++;
      if (phase_o == 3'd7 || n > 7) done = 1;
      else begin
        @(negedge clk);
        if (phase_o == 3'd0) done = 1;
      end
    end
    chk(tr == v.trail, {t, " R2 phase trail"}, {14'd0, tr}, {14'd0, v.trail});
    chk(n == int'(v.cyc), {t, " R2 phase count"}, n, {28'd0, v.cyc});
    chk(acc_o == v.acc, {t, " accumulator"}, {16'd0, acc_o}, {16'd0, v.acc});
    chk(pc_o == 12'(k + 1), "R3 program counter", {20'd0, pc_o}, k + 1);
    if (v.instr[15:12] == 4'h2) begin
      chk(saw_wr && wa == v.instr[11:0], "R6 store address", {20'd0, wa}, {20'd0, v.instr[11:0]});
      chk(wd == v.acc, "R6 store data", {16'd0, wd}, {16'd0, v.acc});
    end else begin
      chk(!saw_wr, {t, " R10 no write"}, {31'd0, saw_wr}, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) mem[i] = VEC[i].instr;
    mem[8'h80] = 16'h1234;
    mem[8'h81] = 16'hF00F;
    mem[8'h82] = 16'hFFFF;
    mem[8'h83] = 16'h0000;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(phase_o == 3'd0, "R1 reset phase", {29'd0, phase_o}, 32'd0);
    chk(pc_o == 12'd0 && acc_o == 16'd0, "R1 reset pc/acc", {4'd0, pc_o, acc_o}, 32'd0);
    chk(!halted && !mem_wr, "R1 reset halted/wr", {30'd0, halted, mem_wr}, 32'd0);

    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) run_one(k);

    chk(mem[8'h83] == 16'h0243, "R6 memory word after store", {16'd0, mem[8'h83]}, 32'h0243);

    // R8 halted stays put
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(phase_o == 3'd7 && halted, "R8 halt holds", {28'd0, halted, phase_o}, 32'hF);
      chk(!mem_rd && !mem_wr && pc_o == 12'd8, "R8 halt quiet", {18'd0, mem_rd, mem_wr, pc_o}, 32'd8);
    end

    // R1 reset in the middle of an instruction
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_one(0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(phase_o == 3'd0 && pc_o == 12'd0, "R1 mid-instruction reset", {17'd0, phase_o, pc_o}, 32'd0);
    chk(acc_o == 16'd0 && !halted, "R1 mid-instruction reset acc", {15'd0, halted, acc_o}, 32'd0);
    rst_n = 1'b1;
    run_one(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule